// File: doc/BRIEF.md
# Sequenced Calibration Register Bank

This block stores ten 14-bit calibration coefficients for a data converter: a gain word, an offset word and eight DAC trim words. They sit at fixed indices: gain at 0, offset at 1, and DAC trims 1 to 8 at indices 2 to 9. A host reaches all of them through one data port. The port has no address. An internal pointer walks through a group of registers that a control write selects.

A control write loads a 2-bit group select and a 2-bit read select, and it rewinds the pointer to the first register of the group. The host then moves whole 16-bit words, or pairs of bytes with the low byte first. The pointer steps after each complete register access and wraps to the start after the last register of the group. A separate load port lets a calibration engine overwrite any register directly without disturbing the host sequence.

Top module: `cal_seq_bank`

## Requirements
- R1: After reset the gain and offset registers hold 0x2000, all eight DAC registers hold 0x0000, `seq_busy` is 0, `host_rdata` is 0, and no sequence is active.
- R2: The group select defines the access sequence. Code 00 walks indices 0 to 9 in order. Code 01 walks gain (0) then offset (1). Code 10 holds offset (1) only. Code 11 holds gain (0) only.
- R3: After the last register of the active group is accessed, the pointer returns to the first register of that group. The first register is offset for code 10 and gain for every other code.
- R4: A word-mode write (`host_byte_mode`=0) stores `host_wdata[13:0]` and ignores bits 15:14. A word-mode read returns `{2'b00, reg[13:0]}`.
- R5: In byte mode, a low access (`host_hben`=0) moves bits 7:0. A high access (`host_hben`=1) moves bits 13:8 in `host_wdata[5:0]` or in `host_rdata[5:0]`, with zeros above. Only the high access advances the pointer, and a high write commits the whole register.
- R6: The bank can be read only when the read select held is 10. With any other read select, `host_rdata` is 0 and a read strobe neither moves the pointer nor changes any register.
- R7: A control write in any state rewinds the pointer and leaves all register contents unchanged. A host strobe in the same cycle as a control write is ignored.
- R8: A load-port write (`ld_en`, `ld_idx`, `ld_data`) updates the indexed register and does not move the pointer. When the host writes the same register in the same cycle, the load data wins.
- R9: A host write before the first control write since reset changes no register.
- R10: `seq_busy` is 1 exactly when the active group has more than one register and the pointer is past its first register. It is 0 in the cycle after any control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_grp | input | 2 | Register group select loaded by a control write |
| ctrl_rdsel | input | 2 | Read select loaded by a control write (10 enables bank reads) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_byte_mode | input | 1 | 1 selects byte transfers, 0 selects word transfers |
| host_hben | input | 1 | Byte mode: 0 selects the low byte, 1 selects the high byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the register at the pointer |
| ld_en | input | 1 | Internal load strobe |
| ld_idx | input | 4 | Internal load register index (0 to 9) |
| ld_data | input | 14 | Internal load data |
| seq_busy | output | 1 | Pointer is partway through a multi-register group |

## Verification
The assertions assume that the host does not assert read and write strobes in the same cycle and that a load is never issued in the same cycle as a control write. The bench respects both conditions. It drives each strobe for one full cycle, starting from a falling edge, and never combines a control write with a host or load strobe. The only place it overlaps strobes on purpose is the host-write/load collision required by R8. The stuck-pointer checks count on byte transfers starting with the low byte, and every byte-mode sequence in the bench does so.

// File: rtl/cal_bank_pkg.sv
package cal_bank_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    GRP_ALL      = 2'b00,
    GRP_GAIN_OFS = 2'b01,
    GRP_OFS      = 2'b10,
    GRP_GAIN     = 2'b11
  } grp_e;

  localparam logic [1:0] RDSEL_BANK = 2'b10;
endpackage

// File: rtl/cal_ptr_seq.sv
module cal_ptr_seq
  import cal_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 10,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [1:0]       ctrl_grp,
  input  logic [1:0]       ctrl_rdsel,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             host_byte_mode,
  input  logic             host_hben,
  output logic [IDX_W-1:0] ptr,
  output logic             active,
  output logic             rd_vis,
  output logic             wr_commit,
  output logic             wr_stage,
  output logic             seq_busy
);
  localparam logic [IDX_W-1:0] IDX_GAIN = '0;
  localparam logic [IDX_W-1:0] IDX_OFS  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS - 1);

  function automatic logic [IDX_W-1:0] first_of(grp_e g);
    return (g == GRP_OFS) ? IDX_OFS : IDX_GAIN;
  endfunction

  function automatic logic [IDX_W-1:0] last_of(grp_e g);
    case (g)
      GRP_ALL:               return IDX_LAST;
      GRP_GAIN_OFS, GRP_OFS: return IDX_OFS;
      default:               return IDX_GAIN;
    endcase
  endfunction

  logic [IDX_W-1:0] ptr_q, ptr_d;
  grp_e             grp_q, grp_d;
  logic [1:0]       rdsel_q, rdsel_d;
  logic             active_q, active_d;
  logic             rd_ok, wr_ok, full_acc, step;
  logic             multi;

  always_comb begin
    rd_ok     = !ctrl_we && active_q && (rdsel_q == RDSEL_BANK) && host_rd && !host_wr;
    wr_ok     = !ctrl_we && active_q && host_wr && !host_rd;
    full_acc  = !host_byte_mode || host_hben;
    step      = (rd_ok || wr_ok) && full_acc;
    wr_commit = wr_ok && full_acc;
    wr_stage  = wr_ok && host_byte_mode && !host_hben;
    multi     = (grp_q == GRP_ALL) || (grp_q == GRP_GAIN_OFS);
  end

  always_comb begin
    ptr_d    = ptr_q;
    grp_d    = grp_q;
    rdsel_d  = rdsel_q;
    active_d = active_q;
    if (ctrl_we) begin
      grp_d    = grp_e'(ctrl_grp);
      rdsel_d  = ctrl_rdsel;
      active_d = 1'b1;
      ptr_d    = first_of(grp_e'(ctrl_grp));
    end else if (step) begin
      if (ptr_q == last_of(grp_q)) ptr_d = first_of(grp_q);
      else                         ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= IDX_GAIN;
      grp_q    <= GRP_ALL;
      rdsel_q  <= 2'b00;
      active_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      grp_q    <= grp_d;
      rdsel_q  <= rdsel_d;
      active_q <= active_d;
    end
  end

  assign ptr      = ptr_q;
  assign active   = active_q;
  assign rd_vis   = active_q && (rdsel_q == RDSEL_BANK);
  assign seq_busy = active_q && multi && (ptr_q != first_of(grp_q));
endmodule

// File: rtl/cal_byte_stage.sv
module cal_byte_stage
  import cal_bank_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_en,
  input  logic              byte_mode,
  input  logic [BUS_W-1:0]  wdata,
  output logic [DATA_W-1:0] commit_data
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              unused_top;

  assign unused_top = ^wdata[BUS_W-1:DATA_W];

  always_comb begin
    lo_d = lo_q;
    if (stage_en) lo_d = wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  always_comb begin
    if (byte_mode) commit_data = {wdata[HI_W-1:0], lo_q};
    else           commit_data = wdata[DATA_W-1:0];
  end
endmodule

// File: rtl/cal_reg_file.sv
module cal_reg_file #(
  parameter int unsigned     NUM_REGS = 10,
  parameter int unsigned     DATA_W   = 14,
  parameter int unsigned     IDX_W    = 4,
  parameter logic [DATA_W-1:0] GAIN_RST = 14'h2000,
  parameter logic [DATA_W-1:0] OFS_RST  = 14'h2000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [IDX_W-1:0]             ld_idx,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic                         hw_en,
  input  logic [IDX_W-1:0]             hw_idx,
  input  logic [DATA_W-1:0]            hw_data,
  output logic [NUM_REGS*DATA_W-1:0]   bank_flat
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (gi == 0) ? GAIN_RST : ((gi == 1) ? OFS_RST : '0);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);

    logic [DATA_W-1:0] q, d;
    logic              ld_hit, hw_hit;

    always_comb begin
      ld_hit = ld_en && (ld_idx == MY_IDX);
      hw_hit = hw_en && (hw_idx == MY_IDX);
      d      = q;
      if (ld_hit)      d = ld_data;
      else if (hw_hit) d = hw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end

    assign bank_flat[gi*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/cal_seq_bank.sv
module cal_seq_bank
  import cal_bank_pkg::*;
#(
  parameter int unsigned       NUM_DAC  = 8,
  parameter int unsigned       DATA_W   = 14,
  parameter int unsigned       BUS_W    = 16,
  parameter logic [DATA_W-1:0] GAIN_RST = 14'h2000,
  parameter logic [DATA_W-1:0] OFS_RST  = 14'h2000,
  localparam int unsigned      NUM_REGS = NUM_DAC + 2,
  localparam int unsigned      IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_grp,
  input  logic [1:0]        ctrl_rdsel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_byte_mode,
  input  logic              host_hben,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  output logic              seq_busy
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;

  logic [1:0]                 rst_pipe_q;
  logic                       rst_int_n;
  logic [IDX_W-1:0]           cur_ptr;
  logic                       seq_active;
  logic                       rd_vis, wr_commit, wr_stage;
  logic [DATA_W-1:0]          commit_data;
  logic [NUM_REGS*DATA_W-1:0] bank_flat;
  logic [DATA_W-1:0]          cur_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  cal_ptr_seq #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .ctrl_we(ctrl_we), .ctrl_grp(ctrl_grp), .ctrl_rdsel(ctrl_rdsel),
    .host_rd(host_rd), .host_wr(host_wr),
    .host_byte_mode(host_byte_mode), .host_hben(host_hben),
    .ptr(cur_ptr), .active(seq_active), .rd_vis(rd_vis),
    .wr_commit(wr_commit), .wr_stage(wr_stage), .seq_busy(seq_busy)
  );

  cal_byte_stage #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_int_n),
    .stage_en(wr_stage), .byte_mode(host_byte_mode),
    .wdata(host_wdata), .commit_data(commit_data)
  );

  cal_reg_file #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .GAIN_RST(GAIN_RST), .OFS_RST(OFS_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .hw_en(wr_commit), .hw_idx(cur_ptr), .hw_data(commit_data),
    .bank_flat(bank_flat)
  );

  always_comb begin
    cur_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cur_ptr == IDX_W'(i)) cur_word = bank_flat[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (rd_vis) begin
      if (!host_byte_mode)
        host_rdata = {{(BUS_W-DATA_W){1'b0}}, cur_word};
      else if (host_hben)
        host_rdata = {{(BUS_W-HI_W){1'b0}}, cur_word[DATA_W-1:BYTE_W]};
      else
        host_rdata = {{(BUS_W-BYTE_W){1'b0}}, cur_word[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/cal_seq_bank_chk.sv
module cal_seq_bank_chk #(
  parameter int unsigned NUM_REGS = 10,
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned IDX_W    = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctrl_we,
  input logic                       ld_en,
  input logic                       host_rd,
  input logic                       host_wr,
  input logic [BUS_W-1:0]           host_rdata,
  input logic                       seq_busy,
  input logic [IDX_W-1:0]           ptr_q,
  input logic                       active_q,
  input logic [NUM_REGS*DATA_W-1:0] bank_flat
);
  // R4
  rdata_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[BUS_W-1:DATA_W] == '0);

  // R7
  ctrl_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ld_en) |=> $stable(bank_flat));

  // R10
  ctrl_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !seq_busy);

  // R8
  load_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ctrl_we && !host_rd && !host_wr) |=> $stable(ptr_q));

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !ctrl_we && !ld_en) |=> $stable(bank_flat));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < IDX_W'(NUM_REGS));
endmodule

bind cal_seq_bank cal_seq_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BUS_W(BUS_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ld_en(ld_en),
  .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
  .seq_busy(seq_busy), .ptr_q(cur_ptr), .active_q(seq_active),
  .bank_flat(bank_flat)
);

// File: tb/cal_seq_bank_bench.sv
module cal_seq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [1:0]  ctrl_grp, ctrl_rdsel;
  logic        host_rd, host_wr, host_byte_mode, host_hben;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        ld_en;
  logic [3:0]  ld_idx;
  logic [13:0] ld_data;
  logic        seq_busy;

  int checks = 0;
  int errors = 0;
  logic [13:0] m [10];
  logic [15:0] rd_d;
  logic        rd_b;

  always #10 clk = ~clk;

  cal_seq_bank u_cal_seq_bank (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_grp(ctrl_grp),
    .ctrl_rdsel(ctrl_rdsel), .host_rd(host_rd), .host_wr(host_wr),
    .host_byte_mode(host_byte_mode), .host_hben(host_hben),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_data(ld_data), .seq_busy(seq_busy)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int glen(input int g);
    case (g) 0: return 10; 1: return 2; default: return 1; endcase
  endfunction

  function automatic int gidx(input int g, input int p);
    case (g) 0, 1: return p; 2: return 1; default: return 0; endcase
  endfunction

  function automatic logic [13:0] val(input int i, input int k);
    return 14'(i * 1111 + k * 2621 + 291);
  endfunction

  task automatic ctrl(input int g, input logic [1:0] rs);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_grp = 2'(g); ctrl_rdsel = rs;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic rd(input logic bm, input logic hb);
    @(negedge clk);
    host_rd = 1'b1; host_byte_mode = bm; host_hben = hb;
    #1 rd_d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
    rd_b = seq_busy;
  endtask

  task automatic wr(input logic bm, input logic hb, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_byte_mode = bm; host_hben = hb; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic ld(input int idx, input logic [13:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic readall(input string req);
    ctrl(0, 2'b10);
    for (int i = 0; i < 10; i++) begin
      rd(1'b0, 1'b0);
      chk(req, rd_d, {2'b00, m[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; ctrl_we = 0; ctrl_grp = 0; ctrl_rdsel = 0;
    host_rd = 0; host_wr = 0; host_byte_mode = 0; host_hben = 0;
    host_wdata = 0; ld_en = 0; ld_idx = 0; ld_data = 0;
    for (int i = 0; i < 10; i++) m[i] = (i < 2) ? 14'h2000 : 14'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset outputs
    chk("R1 busy", {15'd0, seq_busy}, 16'd0);
    chk("R1 rdata", host_rdata, 16'd0);

    // R9 write before any control write is dropped; R6 read gives zero
    wr(1'b0, 1'b0, 16'h1555);
    rd(1'b0, 1'b0);
    chk("R6 inactive read", rd_d, 16'd0);
    readall("R1 R9 defaults");

    // R8 load every register, R2 R3 R10 walk each group
    for (int i = 0; i < 10; i++) begin
      ld(i, val(i, 0));
      m[i] = val(i, 0);
    end
    for (int g = 0; g < 4; g++) begin
      ctrl(g, 2'b10);
      for (int p = 0; p <= glen(g); p++) begin
        int pos;
        pos = p % glen(g);
        rd(1'b0, 1'b0);
        chk("R2 R3 sequence", rd_d, {2'b00, m[gidx(g, pos)]});
        chk("R10 busy", {15'd0, rd_b},
            {15'd0, (glen(g) > 1) && (((pos + 1) % glen(g)) != 0)});
      end
    end

    // R4 word writes per group with top bits set
    for (int g = 0; g < 4; g++) begin
      ctrl(g, 2'b00);
      for (int p = 0; p < glen(g); p++) begin
        wr(1'b0, 1'b0, {2'b11, val(gidx(g, p), g + 1)});
        m[gidx(g, p)] = val(gidx(g, p), g + 1);
      end
      readall("R4 word write");
    end

    // R5 byte-mode writes then byte-mode reads
    ctrl(0, 2'b00);
    for (int i = 0; i < 10; i++) begin
      wr(1'b1, 1'b0, {8'hA5, val(i, 7)[7:0]});
      wr(1'b1, 1'b1, {10'h3C3, val(i, 7)[13:8]});
      m[i] = val(i, 7);
    end
    ctrl(0, 2'b10);
    for (int i = 0; i < 10; i++) begin
      rd(1'b1, 1'b0);
      chk("R5 low byte", rd_d, {8'h00, m[i][7:0]});
      rd(1'b1, 1'b0);
      chk("R5 low repeat", rd_d, {8'h00, m[i][7:0]});
      rd(1'b1, 1'b1);
      chk("R5 high byte", rd_d, {10'd0, m[i][13:8]});
    end

    // R6 other read selects give zero and do not step the pointer
    for (int rs = 0; rs < 4; rs++) begin
      if (rs == 2) continue;
      ctrl(0, 2'(rs));
      rd(1'b0, 1'b0);
      chk("R6 masked read", rd_d, 16'd0);
    end
    rd(1'b0, 1'b0);
    rd(1'b0, 1'b0);
    wr(1'b0, 1'b0, 16'h0ABC);
    m[0] = 14'h0ABC;
    readall("R6 pointer held");

    // R7 abort mid-sequence rewinds without altering contents
    ctrl(0, 2'b10);
    for (int k = 0; k < 4; k++) rd(1'b0, 1'b0);
    ctrl(0, 2'b10);
    rd(1'b0, 1'b0);
    chk("R7 rewind", rd_d, {2'b00, m[0]});
    readall("R7 contents");

    // R8 load wins over host write to the same register
    ctrl(3, 2'b00);
    @(negedge clk);
    host_wr = 1'b1; host_byte_mode = 1'b0; host_wdata = 16'h1111;
    ld_en = 1'b1; ld_idx = 4'd0; ld_data = 14'h2222;
    @(negedge clk);
    host_wr = 1'b0; ld_en = 1'b0;
    m[0] = 14'h2222;
    ctrl(2, 2'b00);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = 16'h0333;
    ld_en = 1'b1; ld_idx = 4'd4; ld_data = 14'h0444;
    @(negedge clk);
    host_wr = 1'b0; ld_en = 1'b0;
    m[1] = 14'h0333; m[4] = 14'h0444;
    readall("R8 priority");

    // R8 load does not move the pointer
    ctrl(0, 2'b10);
    rd(1'b0, 1'b0);
    rd(1'b0, 1'b0);
    ld(5, 14'h1357);
    m[5] = 14'h1357;
    rd(1'b0, 1'b0);
    chk("R8 pointer kept", rd_d, {2'b00, m[2]});
    readall("R8 load value");

    summary();
  end
endmodule